// File: doc/BRIEF.md
# Power On/Off Request Controller

This block watches a single power-enable pin and decides when the power sequencer should start a power-up or a power-down. The pin can act in one of three ways. It can be a level enable. It can be an active-low push-button. It can be the digital output of a supply-sense comparator. A two-flop synchronizer comes first, then a filter that counts separate qualification times for the on and off directions. A small state machine then turns the filtered pin state into single-cycle start pulses for the sequencer.

The controller also handles four other events:

- **Supply POR.** It waits for the supply-POR-good flag before it allows any power-up.
- **Faults and cold resets.** After a shutdown fault or a cold reset it restarts on its own if the pin still asks for power.
- **Software off-request.** After this strobe it requires a fresh on-request.
- **First supply detect.** When this option is enabled, it can force the very first power-up regardless of the pin.

The sequencer reports progress through `seq_active`. This input ends a pending power-up when it rises, and ends a pending power-down when it falls.

Top module: `pwr_req_ctrl`

## Requirements
- R1: In level mode (`mode_sel` = 0, and 3 is also treated as level), `pu_start` pulses once the synchronized pin has been high for RISE_BASE·2^`degl_sel` consecutive clocks. A shorter high glitch produces no pulse.
- R2: In level mode while ON, `pd_start` pulses once the pin has been low for FALL_BASE·2^`degl_sel` consecutive clocks. A shorter low glitch produces no pulse.
- R3: In button mode (`mode_sel` = 1, pin low = pressed), holding the button for RISE_BASE·2^`degl_sel` clocks starts power-up. While ON, a press held for PB_OFF clocks starts power-down, but only after a release of PB_REL clocks has been seen since ACTIVE.
- R4: In sense mode (`mode_sel` = 2), power-up starts as soon as the synchronized pin is high, with no qualification time. Power-down needs a low of FALL_BASE·2^`degl_sel` clocks.
- R5: No power-up starts while `por_good` is low. A button press is counted only from the clock in which `por_good` is high.
- R6: A `fault_evt` or `cold_rst_evt` pulse while ON or powering up moves the block to wait for `seq_active` low, with no `pd_start`. Power-up then restarts by itself, 3 clocks after the event when `seq_active` drops with it. In level and sense modes this restart needs the pin to be still on; in button mode it needs no press.
- R7: `sw_off_req` while ON gives `pd_start` on the next clock. The next power-up needs the pin to go off and then on again. In level and sense modes the off qualification for this re-arm is SWOFF_FALL clocks. In button mode a release followed by a full press is needed.
- R8: With `fsd_en` set, the first power-up after reset starts as soon as `por_good` is high, whatever the pin state. It raises `pu_src_fsd` instead of `pu_src_pin`. Later power-ups do not use this override.
- R9: The first-supply override holds only until `seq_active` rises. A level pin that is then off gives `pd_start` 2 clocks after `seq_active` rises; a pin that is on gives none.
- R10: `pu_start` and `pd_start` are single-cycle pulses. `pu_src_pin` and `pu_src_fsd` are high only together with `pu_start` (a restart raises neither). Off-requests are ignored until `seq_active` has risen after a power-up. A new power-up is held off until `seq_active` has fallen after a power-down.
- R11: While `rst` is high, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_raw | input | 1 | Asynchronous enable / button / sense pin level |
| mode_sel | input | 2 | 0 level, 1 button, 2 sense, 3 level |
| degl_sel | input | 2 | Qualification time scale, multiplier 2^n |
| por_good | input | 1 | Supply above POR threshold |
| sw_off_req | input | 1 | One-cycle software off-request strobe |
| fault_evt | input | 1 | One-cycle shutdown-fault strobe |
| cold_rst_evt | input | 1 | One-cycle cold-reset strobe |
| fsd_en | input | 1 | Enable power-up on first supply |
| seq_active | input | 1 | Sequencer has reached ACTIVE |
| pu_start | output | 1 | One-cycle start-power-up request |
| pd_start | output | 1 | One-cycle start-power-down request |
| pu_src_pin | output | 1 | Power-up caused by a pin event (with `pu_start`) |
| pu_src_fsd | output | 1 | Power-up caused by first supply detect (with `pu_start`) |

## Verification
- **Pin changes.** A pin change passes two synchronizer flops, then T filter counts, then the output register. The matching pulse is therefore due T+3 clocks after the pin is driven; for a sense-mode rise, T is 1.
- **Strobes and flags.** A software off-request gives its pulse 1 clock after it is driven. A rise of `por_good` with the pin already qualified also gives its pulse after 1 clock. A fault that drops `seq_active` gives its restart 3 clocks later. A drop of `seq_active` after a pending power-down gives its power-up 2 clocks later.
- **How the checks measure timing.** Each check drives one stimulus and then counts clocks until the first pulse. It compares that count exactly with the value a bench function computes from these latencies.
- **Checks for absent pulses.** Cases where no pulse must appear, such as glitches, pending sequences and missing re-arm edges, are watched over a window longer than the longest qualification time.

// File: rtl/pwr_req_pkg.sv
package pwr_req_pkg;

  localparam logic [1:0] MODE_LEVEL  = 2'd0;
  localparam logic [1:0] MODE_BUTTON = 2'd1;
  localparam logic [1:0] MODE_SENSE  = 2'd2;

  typedef enum logic [1:0] {
    ST_OFF,
    ST_RAMP_UP,
    ST_ON,
    ST_RAMP_DN
  } req_state_e;

  function automatic int max_of3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/preq_sync.sv
module preq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= din;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], din};
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];

endmodule

// File: rtl/preq_filter.sv
module preq_filter #(
  parameter int CW = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          lvl,
  input  logic [CW-1:0] thr_set,
  input  logic [CW-1:0] thr_clr,
  output logic          state
);

  logic [CW-1:0] cnt;
  logic [CW-1:0] thr_cur;
  logic [CW:0]   cnt_next;

  always_comb begin
    thr_cur  = state ? thr_clr : thr_set;
    cnt_next = {1'b0, cnt} + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      state <= 1'b0;
      cnt   <= '0;
    end else if (lvl == state) begin
      cnt <= '0;
    end else if (cnt_next >= {1'b0, thr_cur}) begin
      state <= lvl;
      cnt   <= '0;
    end else begin
      cnt <= cnt_next[CW-1:0];
    end
  end

  AST_FILT_FOLLOWS_LVL: assert property (@(posedge clk) disable iff (rst)
    (state != $past(state)) && !$past(clr) |-> ($past(lvl) == state)) // R1
    else $error("filter changed against its input");

  AST_FILT_CLR_OFF: assert property (@(posedge clk) disable iff (rst)
    $past(clr) |-> !state) // R5
    else $error("filter not cleared");

endmodule

// File: rtl/preq_hold.sv
module preq_hold #(
  parameter int CW = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic [CW-1:0] thr,
  output logic          done
);

  logic [CW-1:0] cnt;
  logic [CW:0]   cnt_next;

  assign cnt_next = {1'b0, cnt} + 1'b1;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt  <= '0;
      done <= 1'b0;
    end else if (!done) begin
      if (cnt_next >= {1'b0, thr}) done <= 1'b1;
      else                         cnt  <= cnt_next[CW-1:0];
    end
  end

  AST_HOLD_NEEDS_RUN: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(run)) // R3
    else $error("hold timer done without run");

endmodule

// File: rtl/preq_fsm.sv
module preq_fsm
  import pwr_req_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic is_pb,
  input  logic dg_on,
  input  logic pressed_raw,
  input  logic hold_done,
  input  logic por_good,
  input  logic sw_off_req,
  input  logic fault_evt,
  input  logic cold_rst_evt,
  input  logic fsd_en,
  input  logic seq_active,
  output logic swoff_fast,
  output logic hold_run,
  output logic pu_start,
  output logic pd_start,
  output logic src_pin,
  output logic src_fsd
);

  req_state_e st;
  logic need_edge, seen_off, restart, first_done, pb_armed;
  logic fsd_go, restart_go, pin_go, go, abort, pin_off;

  always_comb begin
    fsd_go     = fsd_en && !first_done && por_good;
    restart_go = restart && por_good && (is_pb || dg_on);
    pin_go     = por_good && dg_on && (!need_edge || seen_off);
    go         = fsd_go || restart_go || pin_go;
    abort      = fault_evt || cold_rst_evt;
    pin_off    = is_pb ? hold_done : !dg_on;
  end

  assign hold_run = is_pb && pb_armed && (st == ST_ON) && pressed_raw;

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_OFF;
      need_edge  <= 1'b0;
      seen_off   <= 1'b0;
      restart    <= 1'b0;
      first_done <= 1'b0;
      pb_armed   <= 1'b0;
      swoff_fast <= 1'b0;
      pu_start   <= 1'b0;
      pd_start   <= 1'b0;
      src_pin    <= 1'b0;
      src_fsd    <= 1'b0;
    end else begin
      pu_start <= 1'b0;
      pd_start <= 1'b0;
      src_pin  <= 1'b0;
      src_fsd  <= 1'b0;
      case (st)
        ST_OFF: begin
          if (go) begin
            pu_start   <= 1'b1;
            src_fsd    <= fsd_go;
            src_pin    <= !fsd_go && !restart_go;
            first_done <= 1'b1;
            restart    <= 1'b0;
            need_edge  <= 1'b0;
            seen_off   <= 1'b0;
            swoff_fast <= 1'b0;
            st         <= ST_RAMP_UP;
          end else if (!dg_on) begin
            seen_off <= 1'b1;
          end
        end
        ST_RAMP_UP: begin
          if (abort) begin
            restart   <= 1'b1;
            need_edge <= 1'b0;
            st        <= ST_RAMP_DN;
          end else if (seq_active) begin
            pb_armed <= 1'b0;
            st       <= ST_ON;
          end
        end
        ST_ON: begin
          if (abort) begin
            restart   <= 1'b1;
            need_edge <= 1'b0;
            st        <= ST_RAMP_DN;
          end else if (sw_off_req || pin_off) begin
            pd_start   <= 1'b1;
            need_edge  <= 1'b1;
            seen_off   <= 1'b0;
            restart    <= 1'b0;
            swoff_fast <= sw_off_req && !is_pb;
            st         <= ST_RAMP_DN;
          end else if (is_pb && !dg_on) begin
            pb_armed <= 1'b1;
          end
        end
        default: begin
          if (!dg_on) seen_off <= 1'b1;
          if (!seq_active) st <= ST_OFF;
        end
      endcase
    end
  end

  AST_PU_SINGLE: assert property (@(posedge clk) disable iff (rst)
    pu_start |=> !pu_start) // R10
    else $error("pu_start longer than one cycle");

  AST_PD_SINGLE: assert property (@(posedge clk) disable iff (rst)
    pd_start |=> !pd_start) // R10
    else $error("pd_start longer than one cycle");

  AST_NO_BOTH: assert property (@(posedge clk) disable iff (rst)
    !(pu_start && pd_start)) // R10
    else $error("both requests at once");

  AST_PU_NEEDS_POR: assert property (@(posedge clk) disable iff (rst)
    pu_start |-> $past(por_good)) // R5
    else $error("power-up without por_good");

  AST_SRC_WITH_PU: assert property (@(posedge clk) disable iff (rst)
    (src_pin || src_fsd) |-> pu_start) // R8
    else $error("source flag without power-up");

  AST_SRC_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(src_pin && src_fsd)) // R8
    else $error("two source flags");

  AST_ABORT_NO_PD: assert property (@(posedge clk) disable iff (rst)
    $past(fault_evt || cold_rst_evt) |-> !pd_start) // R6
    else $error("power-down pulse after fault");

endmodule

// File: rtl/pwr_req_ctrl.sv
module pwr_req_ctrl
  import pwr_req_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int RISE_BASE   = 4,
  parameter int FALL_BASE   = 8,
  parameter int SWOFF_FALL  = 3,
  parameter int PB_REL      = 3,
  parameter int PB_OFF      = 40
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       pin_raw,
  input  logic [1:0] mode_sel,
  input  logic [1:0] degl_sel,
  input  logic       por_good,
  input  logic       sw_off_req,
  input  logic       fault_evt,
  input  logic       cold_rst_evt,
  input  logic       fsd_en,
  input  logic       seq_active,
  output logic       pu_start,
  output logic       pd_start,
  output logic       pu_src_pin,
  output logic       pu_src_fsd
);

  localparam int MAX_T = max_of3(max_of3(RISE_BASE << 3, FALL_BASE << 3, PB_OFF),
                                 SWOFF_FALL, PB_REL);
  localparam int CW    = $clog2(MAX_T + 1);

  logic          pin_s;
  logic          is_pb, is_sense;
  logic [CW-1:0] rise_sel, fall_sel, thr_on, thr_off;
  logic          filt_lvl, filt_clr, dg_on;
  logic          swoff_fast, hold_run, hold_done;

  preq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .din (pin_raw),
    .dout(pin_s)
  );

  always_comb begin
    is_pb    = (mode_sel == MODE_BUTTON);
    is_sense = (mode_sel == MODE_SENSE);
    rise_sel = CW'(RISE_BASE) << degl_sel;
    fall_sel = CW'(FALL_BASE) << degl_sel;
    thr_on   = is_sense ? CW'(1) : rise_sel;
    if (is_pb)           thr_off = CW'(PB_REL);
    else if (swoff_fast) thr_off = CW'(SWOFF_FALL);
    else                 thr_off = fall_sel;
    filt_lvl = is_pb ? !pin_s : pin_s;
    filt_clr = is_pb && !por_good;
  end

  preq_filter #(.CW(CW)) u_filt (
    .clk    (clk),
    .rst    (rst),
    .clr    (filt_clr),
    .lvl    (filt_lvl),
    .thr_set(thr_on),
    .thr_clr(thr_off),
    .state  (dg_on)
  );

  preq_hold #(.CW(CW)) u_hold (
    .clk (clk),
    .rst (rst),
    .run (hold_run),
    .thr (CW'(PB_OFF)),
    .done(hold_done)
  );

  preq_fsm u_fsm (
    .clk         (clk),
    .rst         (rst),
    .is_pb       (is_pb),
    .dg_on       (dg_on),
    .pressed_raw (!pin_s),
    .hold_done   (hold_done),
    .por_good    (por_good),
    .sw_off_req  (sw_off_req),
    .fault_evt   (fault_evt),
    .cold_rst_evt(cold_rst_evt),
    .fsd_en      (fsd_en),
    .seq_active  (seq_active),
    .swoff_fast  (swoff_fast),
    .hold_run    (hold_run),
    .pu_start    (pu_start),
    .pd_start    (pd_start),
    .src_pin     (pu_src_pin),
    .src_fsd     (pu_src_fsd)
  );

endmodule

// File: tb/sim_pwr_req_ctrl.sv
module sim_pwr_req_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int RISE_BASE  = 4;
  localparam int FALL_BASE  = 8;
  localparam int SWOFF_FALL = 3;
  localparam int PB_REL     = 3;
  localparam int PB_OFF     = 40;
  localparam int WATCHDOG   = 150000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pin_raw = 1'b0;
  logic [1:0] mode_sel = 2'd0;
  logic [1:0] degl_sel = 2'd0;
  logic por_good = 1'b1, sw_off_req = 1'b0, fault_evt = 1'b0, cold_rst_evt = 1'b0;
  logic fsd_en = 1'b0, seq_active = 1'b0;
  logic pu_start, pd_start, pu_src_pin, pu_src_fsd;

  int nchk = 0, nfail = 0, pu_cnt = 0, pd_cnt = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwr_req_ctrl #(
    .SYNC_STAGES(2), .RISE_BASE(RISE_BASE), .FALL_BASE(FALL_BASE),
    .SWOFF_FALL(SWOFF_FALL), .PB_REL(PB_REL), .PB_OFF(PB_OFF)
  ) u0 (
    .clk(clk), .rst(rst), .pin_raw(pin_raw), .mode_sel(mode_sel), .degl_sel(degl_sel),
    .por_good(por_good), .sw_off_req(sw_off_req), .fault_evt(fault_evt),
    .cold_rst_evt(cold_rst_evt), .fsd_en(fsd_en), .seq_active(seq_active),
    .pu_start(pu_start), .pd_start(pd_start), .pu_src_pin(pu_src_pin), .pu_src_fsd(pu_src_fsd)
  );

  always @(negedge clk) if (!rst) begin
    if (pu_start) pu_cnt++;
    if (pd_start) pd_cnt++;
  end

  function automatic int rise_t(input int sel); return RISE_BASE << sel; endfunction
  function automatic int fall_t(input int sel); return FALL_BASE << sel; endfunction
  function automatic int pin_lat(input int t);  return t + 3;            endfunction

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic run_until(input int maxn, output int pu_at, output int pd_at,
                           output int spin, output int sfsd);
    pu_at = 0; pd_at = 0; spin = 0; sfsd = 0;
    for (int i = 1; i <= maxn; i++) begin
      tick(1);
      if (pu_start && pu_at == 0) begin pu_at = i; spin = int'(pu_src_pin); sfsd = int'(pu_src_fsd); end
      if (pd_start && pd_at == 0) pd_at = i;
      if (pu_at != 0 || pd_at != 0) break;
    end
  endtask

  task automatic pulse_in(ref logic sig);
    sig = 1'b1; tick(1); sig = 1'b0;
  endtask

  task automatic do_reset(input logic [1:0] m, input logic [1:0] s, input logic fsd,
                          input logic por, input logic pin);
    rst = 1'b1; mode_sel = m; degl_sel = s; fsd_en = fsd; por_good = por;
    pin_raw = pin; seq_active = 1'b0;
    tick(3);
    chk("R11 outputs in reset", int'({pu_start, pd_start, pu_src_pin, pu_src_fsd}), 0);
    rst = 1'b0;
  endtask

  int pu_at, pd_at, spin, sfsd, base, t, tf;

  initial begin
    void'($urandom(32'd1234));
    tick(1);

    // R1: level mode, random scale, short high glitches then a qualified high
    t = int'($urandom % 4);
    do_reset(2'd0, t[1:0], 1'b0, 1'b1, 1'b0);
    tf = fall_t(t); t = rise_t(t);
    tick(4);
    base = pu_cnt;
    for (int k = 0; k < 6; k++) begin
      int w;
      w = 1 + int'($urandom % (t - 1));
      pin_raw = 1'b1; tick(w);
      pin_raw = 1'b0; tick(t + 4);
    end
    chk("R1 high glitch ignored", pu_cnt - base, 0);
    pin_raw = 1'b1;
    run_until(t + 10, pu_at, pd_at, spin, sfsd);
    chk("R1 power-up latency", pu_at, pin_lat(t));
    chk("R10 pin source flag", spin, 1);
    seq_active = 1'b1; tick(3);

    // R2: low glitches while ON, then qualified low
    base = pd_cnt;
    for (int k = 0; k < 6; k++) begin
      int w;
      w = 1 + int'($urandom % (tf - 1));
      pin_raw = 1'b0; tick(w);
      pin_raw = 1'b1; tick(tf + 4);
    end
    chk("R2 low glitch ignored", pd_cnt - base, 0);
    pin_raw = 1'b0;
    run_until(tf + 10, pu_at, pd_at, spin, sfsd);
    chk("R2 power-down latency", pd_at, pin_lat(tf));
    seq_active = 1'b0; tick(2);

    // R4: sense mode, no rise qualification
    t = int'($urandom % 4);
    do_reset(2'd2, t[1:0], 1'b0, 1'b1, 1'b0);
    tf = fall_t(t);
    tick(4);
    pin_raw = 1'b1;
    run_until(20, pu_at, pd_at, spin, sfsd);
    chk("R4 sense power-up latency", pu_at, 4);
    seq_active = 1'b1; tick(3);
    pin_raw = 1'b0;
    run_until(tf + 10, pu_at, pd_at, spin, sfsd);
    chk("R4 sense power-down latency", pd_at, pin_lat(tf));
    seq_active = 1'b0; tick(2);

    // R5: level mode gated by por_good
    do_reset(2'd0, 2'd0, 1'b0, 1'b0, 1'b1);
    base = pu_cnt; tick(20);
    chk("R5 no power-up without POR", pu_cnt - base, 0);
    por_good = 1'b1;
    run_until(10, pu_at, pd_at, spin, sfsd);
    chk("R5 power-up once POR good", pu_at, 1);
    tick(2);

    // R3/R5: button mode held before POR, counted from POR
    t = rise_t(0);
    do_reset(2'd1, 2'd0, 1'b0, 1'b0, 1'b0);
    base = pu_cnt; tick(20);
    chk("R5 press ignored before POR", pu_cnt - base, 0);
    por_good = 1'b1;
    run_until(t + 10, pu_at, pd_at, spin, sfsd);
    chk("R5 press counted from POR", pu_at, t + 1);
    tick(1); seq_active = 1'b1; tick(2);
    base = pd_cnt; tick(50);
    chk("R3 held press not an off-request before release", pd_cnt - base, 0);
    pin_raw = 1'b1; tick(10);
    pin_raw = 1'b0;
    run_until(PB_OFF + 10, pu_at, pd_at, spin, sfsd);
    chk("R3 long press power-down latency", pd_at, PB_OFF + 3);
    tick(1); seq_active = 1'b0;
    base = pu_cnt; tick(20);
    chk("R7 button needs new press", pu_cnt - base, 0);
    pin_raw = 1'b1; tick(10);
    pin_raw = 1'b0;
    run_until(t + 10, pu_at, pd_at, spin, sfsd);
    chk("R3 new press power-up latency", pu_at, pin_lat(t));
    tick(1); seq_active = 1'b1; tick(2);

    // R6: cold reset in button mode restarts without a press
    pin_raw = 1'b1; seq_active = 1'b0; base = pd_cnt;
    pulse_in(cold_rst_evt);
    run_until(9, pu_at, pd_at, spin, sfsd);
    chk("R6 button restart latency", pu_at + 1, 3);
    chk("R6 no pd pulse on cold reset", pd_cnt - base, 0);
    chk("R10 restart sets no source", spin + sfsd, 0);

    // R6/R7/R10: level mode fault, software off and pending sequences
    t = rise_t(0); tf = fall_t(0);
    do_reset(2'd0, 2'd0, 1'b0, 1'b1, 1'b0);
    tick(4);
    pin_raw = 1'b1;
    run_until(t + 10, pu_at, pd_at, spin, sfsd);
    tick(1); seq_active = 1'b1; tick(3);
    seq_active = 1'b0; base = pd_cnt;
    pulse_in(fault_evt);
    run_until(9, pu_at, pd_at, spin, sfsd);
    chk("R6 fault restart latency", pu_at + 1, 3);
    chk("R6 no pd pulse on fault", pd_cnt - base, 0);
    tick(1); seq_active = 1'b1; tick(3);
    sw_off_req = 1'b1;
    run_until(5, pu_at, pd_at, spin, sfsd);
    sw_off_req = 1'b0;
    chk("R7 software off latency", pd_at, 1);
    seq_active = 1'b0;
    base = pu_cnt; tick(30);
    chk("R7 level needs a new edge", pu_cnt - base, 0);
    pin_raw = 1'b0; tick(SWOFF_FALL);
    pin_raw = 1'b1;
    run_until(t + 10, pu_at, pd_at, spin, sfsd);
    chk("R7 short off re-arm latency", pu_at, pin_lat(t));
    tick(1); base = pd_cnt;
    pulse_in(sw_off_req);
    tick(10);
    chk("R10 off ignored while power-up pending", pd_cnt - base, 0);
    seq_active = 1'b1; tick(3);
    pin_raw = 1'b0;
    run_until(tf + 10, pu_at, pd_at, spin, sfsd);
    chk("R2 pin power-down latency", pd_at, pin_lat(tf));
    pin_raw = 1'b1; base = pu_cnt; tick(20);
    chk("R10 on ignored while power-down pending", pu_cnt - base, 0);
    seq_active = 1'b0;
    run_until(10, pu_at, pd_at, spin, sfsd);
    chk("R10 power-up after sequencer idle", pu_at, 2);
    tick(2);

    // R8/R9: first supply detect with pin off
    do_reset(2'd0, 2'd0, 1'b1, 1'b0, 1'b0);
    tick(4);
    por_good = 1'b1;
    run_until(10, pu_at, pd_at, spin, sfsd);
    chk("R8 first supply power-up latency", pu_at, 1);
    chk("R8 first supply source flag", sfsd * 2 + spin, 2);
    base = pd_cnt; tick(10);
    chk("R9 override holds before ACTIVE", pd_cnt - base, 0);
    seq_active = 1'b1;
    run_until(10, pu_at, pd_at, spin, sfsd);
    chk("R9 off pin at ACTIVE powers down", pd_at, 2);
    tick(1); seq_active = 1'b0; tick(2);
    pin_raw = 1'b1;
    run_until(t + 10, pu_at, pd_at, spin, sfsd);
    chk("R8 later power-up from pin", pu_at, pin_lat(t));
    chk("R8 later source is pin", sfsd * 2 + spin, 1);

    // R9: first supply detect with pin on
    do_reset(2'd0, 2'd0, 1'b1, 1'b0, 1'b1);
    tick(4);
    por_good = 1'b1;
    run_until(10, pu_at, pd_at, spin, sfsd);
    chk("R8 first supply power-up pin high", pu_at, 1);
    tick(10); seq_active = 1'b1; base = pd_cnt; tick(20);
    chk("R9 on pin keeps power at ACTIVE", pd_cnt - base, 0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      nchk++; nfail++;
      $display("FAIL watchdog actual=%0d expected=%0d", WATCHDOG, 0);
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

endmodule